// File: doc/BRIEF.md
# Prioritized Interrupt Gate with Sleep Wake-Up

This block sits between a bank of interrupt request lines and a processor core. Each configurable line carries a 3-bit urgency level that software programs through a narrow write port. In that level, 0 is the most urgent. The block filters the pending lines through two masks that act together. The first is a single global block bit. The second is a threshold that removes every line at or below a chosen urgency. The block also compares each line against the level of the handler currently running. From the lines that survive, it picks one winner, raises a take request and presents the vector number. One extra non-maskable line bypasses both masks.

The core acknowledges a take when it enters a handler and signals an exit when the handler returns. The block keeps a stack of the preempted levels, so each exit restores the level that was interrupted. A sleep controller handles two kinds of sleep entry. In wait-for-interrupt sleep, only a request that passes the threshold and the running level wakes the core, although the global bit may still hold back the take itself. In wait-for-event sleep, any pending line wakes the core. A sleep-on-exit control sends the core back to sleep when the outermost handler returns.

Top module: `irq_prio_gate`

## Requirements
- R1: Of the eligible configurable lines, the one with the smallest level number wins, and a tie goes to the lowest line index. `take_vec` carries that index and `take_req` is high while any line is eligible.
- R2: After reset every line level is 0, the global block bit, the threshold and sleep-on-exit are clear, no handler is active and `asleep` is low.
- R3: Writing 1 to bit 0 at address NUM_IRQ sets the global block bit. While that bit is set, no configurable line raises `take_req`.
- R4: The threshold at address NUM_IRQ+1 blocks nothing when it is 0. A nonzero value N blocks every line whose level is N or greater.
- R5: A line is eligible only if its level is strictly smaller than the level of the running handler. A take acknowledge makes the winner's level the running level. An exit acknowledge restores the level that was preempted. When a take and an exit arrive in the same cycle, the take is served.
- R6: In wait-for-interrupt sleep (`sleep_wfe`=0), `wake` rises only for a pending line that passes the threshold and the running level, or for the non-maskable line. The global block bit does not stop the wake. It does stop the take, and the take then appears as soon as the bit is cleared.
- R7: In wait-for-event sleep (`sleep_wfe`=1), any pending line wakes the core, masked or not. A masked line gives `wake` with no `take_req`. An unmasked line gives both in the same cycle.
- R8: With bit 0 at address NUM_IRQ+2 set, an exit acknowledge that ends the outermost handler puts the block into wait-for-interrupt sleep on the next cycle.
- R9: The non-maskable line ignores both masks. It beats every configurable line with vector NUM_IRQ, and it is not taken again while its own handler runs.
- R10: A write to address i < NUM_IRQ sets the level of line i to `cfg_wdata`. The level is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address: 0..NUM_IRQ-1 level, NUM_IRQ block bit, NUM_IRQ+1 threshold, NUM_IRQ+2 sleep-on-exit |
| cfg_wdata | input | PRIO_W | Write data |
| irq_pend | input | NUM_IRQ | Pending configurable lines |
| nmi_pend | input | 1 | Pending non-maskable line |
| sleep_req | input | 1 | Core requests sleep |
| sleep_wfe | input | 1 | Sleep kind: 0 wait-for-interrupt, 1 wait-for-event |
| take_ack | input | 1 | Core enters the handler of the current winner |
| exit_ack | input | 1 | Core returns from the running handler |
| take_req | output | 1 | A request is eligible to be taken |
| take_vec | output | VEC_W | Winner vector, NUM_IRQ for the non-maskable line |
| wake | output | 1 | Wake condition met while asleep |
| asleep | output | 1 | Core is held in sleep |

## Verification
The arbitration is swept over a range of programmed level patterns. For each pattern the bench steps through every threshold value, both states of the global bit, and several pending masks, one of which is all lines pending. This separates three things: the level ordering from the index tie-break, the threshold boundary (level equal to N against level N-1), and the global block bit. Handcrafted nesting sequences check that a pending line at the running level is held back while a more urgent one preempts, and that each exit restores the level it interrupted. The sleep sequences distinguish a request blocked by the threshold from one blocked only by the global bit, and a masked wake-for-event from an unmasked one.

// File: rtl/irq_gate_pkg.sv
// Package: shared types of the interrupt gate.
// Assumes nothing beyond IEEE 1800-2017.
package irq_gate_pkg;

    // Kind of sleep the core has entered.
    typedef enum logic {
        SLP_WFI = 1'b0,
        SLP_WFE = 1'b1
    } sleep_kind_e;

endpackage

// File: rtl/irq_cfg_regs.sv
// Module: configuration registers of the interrupt gate.
// Holds one level per line, the global block bit, the threshold and the
// sleep-on-exit bit. Assumes one write per cycle; writes to unused
// addresses are dropped.
module irq_cfg_regs #(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [ADDR_W-1:0]                cfg_addr,
    input  logic [PRIO_W-1:0]                cfg_wdata,
    output logic [NUM_IRQ-1:0][PRIO_W-1:0]   prio_q,
    output logic                             gmask_q,
    output logic [PRIO_W-1:0]                base_q,
    output logic                             soe_q
);

    localparam logic [ADDR_W-1:0] A_GMASK = ADDR_W'(NUM_IRQ);
    localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(NUM_IRQ + 1);
    localparam logic [ADDR_W-1:0] A_SOE   = ADDR_W'(NUM_IRQ + 2);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
        // Level of line i: reset to most urgent, loaded by its own address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[i] <= '0;
            else if (cfg_we && cfg_addr == ADDR_W'(i))
                prio_q[i] <= cfg_wdata;
        end
    end

    // Global block bit, threshold and sleep-on-exit control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gmask_q <= 1'b0;
            base_q  <= '0;
            soe_q   <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == A_GMASK) gmask_q <= cfg_wdata[0];
            if (cfg_addr == A_BASE)  base_q  <= cfg_wdata;
            if (cfg_addr == A_SOE)   soe_q   <= cfg_wdata[0];
        end
    end

endmodule

// File: rtl/irq_select.sv
// Module: eligibility filter and winner selection.
// Combinational. A line's rank is its level plus one; rank 0 belongs to the
// non-maskable line. Assumes active_rank holds the running handler's rank,
// or 2**PRIO_W+1 when no handler runs.
module irq_select #(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3,
    parameter int RANK_W  = PRIO_W + 1,
    parameter int VEC_W   = 4
) (
    input  logic [NUM_IRQ-1:0]               pend,
    input  logic                             nmi_pend,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0]   prio,
    input  logic                             gmask,
    input  logic [PRIO_W-1:0]                base,
    input  logic [RANK_W-1:0]                active_rank,
    output logic                             take_req,
    output logic [VEC_W-1:0]                 take_vec,
    output logic [RANK_W-1:0]                take_rank,
    output logic                             wfi_wake,
    output logic                             wfe_wake
);

    logic [NUM_IRQ-1:0] open_w;   // would be eligible if the global bit were clear
    logic [NUM_IRQ-1:0] elig_w;   // eligible now
    logic               nmi_ok;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        logic base_ok;
        logic lvl_ok;
        // Threshold filter and running-level filter of line i.
        always_comb begin
            base_ok   = (base == '0) || (prio[i] < base);
            lvl_ok    = ({1'b0, prio[i]} + RANK_W'(1)) < active_rank;
            open_w[i] = pend[i] && base_ok && lvl_ok;
            elig_w[i] = open_w[i] && !gmask;
        end
    end

    assign nmi_ok = nmi_pend && (active_rank != '0);

    // Winner: non-maskable first, then smallest level, ties to lowest index.
    always_comb begin
        logic [PRIO_W:0] best;
        best      = {1'b1, {PRIO_W{1'b0}}};
        take_vec  = '0;
        take_rank = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig_w[i] && ({1'b0, prio[i]} < best)) begin
                best      = {1'b0, prio[i]};
                take_vec  = VEC_W'(i);
                take_rank = {1'b0, prio[i]} + RANK_W'(1);
            end
        end
        if (nmi_ok) begin
            take_vec  = VEC_W'(NUM_IRQ);
            take_rank = '0;
        end
        take_req = nmi_ok || (|elig_w);
    end

    assign wfi_wake = nmi_ok || (|open_w);
    assign wfe_wake = nmi_pend || (|pend);

endmodule

// File: rtl/irq_level_stack.sv
// Module: running-level tracker with a stack of preempted levels.
// A push saves the current rank and installs the new one; a pop restores the
// saved rank. Assumes each push carries a rank strictly below the current
// one, so the depth never exceeds 2**PRIO_W+1.
module irq_level_stack #(
    parameter int PRIO_W = 3,
    parameter int RANK_W = PRIO_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [RANK_W-1:0] push_rank,
    input  logic              pop,
    output logic [RANK_W-1:0] active_rank,
    output logic              depth_one
);

    localparam int                DEPTH = (1 << PRIO_W) + 1;
    localparam int                PTR_W = $clog2(DEPTH + 1);
    localparam logic [RANK_W-1:0] IDLE  = RANK_W'(DEPTH);

    logic [PTR_W-1:0]  depth_q;
    logic [RANK_W-1:0] saved_q [0:(1<<PTR_W)-1];

    // Running rank and stack depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_rank <= IDLE;
            depth_q     <= '0;
        end else if (push && depth_q < PTR_W'(DEPTH)) begin
            active_rank <= push_rank;
            depth_q     <= depth_q + PTR_W'(1);
        end else if (pop && depth_q != '0) begin
            active_rank <= saved_q[depth_q - PTR_W'(1)];
            depth_q     <= depth_q - PTR_W'(1);
        end
    end

    // Save area for preempted ranks; contents are don't-care until pushed.
    always_ff @(posedge clk) begin
        if (push && depth_q < PTR_W'(DEPTH))
            saved_q[depth_q] <= active_rank;
    end

    assign depth_one = (depth_q == PTR_W'(1));

endmodule

// File: rtl/irq_sleep_fsm.sv
// Module: sleep controller.
// Enters sleep on request or on sleep-on-exit, and leaves it when the wake
// rule of the current sleep kind is met. Assumes the wake inputs are
// already filtered by the selector.
module irq_sleep_fsm
    import irq_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic sleep_wfe,
    input  logic soe_enter,
    input  logic wfi_wake,
    input  logic wfe_wake,
    output logic wake,
    output logic asleep
);

    sleep_kind_e kind_q;

    assign wake = asleep && ((kind_q == SLP_WFE) ? wfe_wake : wfi_wake);

    // Sleep state and kind: wake takes precedence, then sleep-on-exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asleep <= 1'b0;
            kind_q <= SLP_WFI;
        end else if (asleep) begin
            if (wake) asleep <= 1'b0;
        end else if (soe_enter) begin
            asleep <= 1'b1;
            kind_q <= SLP_WFI;
        end else if (sleep_req) begin
            asleep <= 1'b1;
            kind_q <= sleep_wfe ? SLP_WFE : SLP_WFI;
        end
    end

endmodule

// File: rtl/irq_prio_gate.sv
// Module: top of the prioritized interrupt gate.
// Ties the configuration registers, the selector, the level stack and the
// sleep controller together. Assumes the core raises take_ack only when it
// actually enters the presented vector, and exit_ack once per return.
module irq_prio_gate #(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = $clog2(NUM_IRQ + 3),
    parameter int VEC_W   = $clog2(NUM_IRQ + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [PRIO_W-1:0]  cfg_wdata,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic               nmi_pend,
    input  logic               sleep_req,
    input  logic               sleep_wfe,
    input  logic               take_ack,
    input  logic               exit_ack,
    output logic               take_req,
    output logic [VEC_W-1:0]   take_vec,
    output logic               wake,
    output logic               asleep
);

    localparam int RANK_W = PRIO_W + 1;

    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q;
    logic                           gmask_q;
    logic [PRIO_W-1:0]              base_q;
    logic                           soe_q;
    logic [RANK_W-1:0]              take_rank;
    logic [RANK_W-1:0]              active_rank;
    logic                           depth_one;
    logic                           wfi_wake;
    logic                           wfe_wake;
    logic                           take_fire;
    logic                           exit_fire;
    logic                           soe_enter;

    irq_cfg_regs #(
        .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .prio_q(prio_q), .gmask_q(gmask_q),
        .base_q(base_q), .soe_q(soe_q)
    );

    irq_select #(
        .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .RANK_W(RANK_W), .VEC_W(VEC_W)
    ) u_sel (
        .pend(irq_pend), .nmi_pend(nmi_pend), .prio(prio_q), .gmask(gmask_q),
        .base(base_q), .active_rank(active_rank), .take_req(take_req),
        .take_vec(take_vec), .take_rank(take_rank), .wfi_wake(wfi_wake),
        .wfe_wake(wfe_wake)
    );

    // Handshake qualification: a take beats a simultaneous exit.
    assign take_fire = take_ack && take_req;
    assign exit_fire = exit_ack && !take_fire;
    assign soe_enter = exit_fire && depth_one && soe_q;

    irq_level_stack #(
        .PRIO_W(PRIO_W), .RANK_W(RANK_W)
    ) u_stack (
        .clk(clk), .rst_n(rst_n), .push(take_fire), .push_rank(take_rank),
        .pop(exit_fire), .active_rank(active_rank), .depth_one(depth_one)
    );

    irq_sleep_fsm u_sleep (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_wfe(sleep_wfe),
        .soe_enter(soe_enter), .wfi_wake(wfi_wake), .wfe_wake(wfe_wake),
        .wake(wake), .asleep(asleep)
    );

endmodule

// File: rtl/irq_prio_gate_chk.sv
// Module: property checker for the interrupt gate, bound to the top.
// Observes ports and the state passed between submodules.
module irq_prio_gate_chk #(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3,
    parameter int VEC_W   = 4,
    parameter int RANK_W  = PRIO_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              take_req,
    input logic [VEC_W-1:0]  take_vec,
    input logic              take_ack,
    input logic              exit_ack,
    input logic              nmi_pend,
    input logic              gmask_q,
    input logic              soe_q,
    input logic [RANK_W-1:0] active_rank,
    input logic              depth_one,
    input logic              wake,
    input logic              asleep
);

    assert_vec_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> (take_vec <= VEC_W'(NUM_IRQ)));

    assert_gmask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gmask_q && !nmi_pend) |-> !take_req);

    assert_take_raises_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_ack && take_req) |=> (active_rank < $past(active_rank)));

    assert_wake_ends_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && wake) |=> !asleep);

    assert_soe_resleeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_ack && !take_ack && depth_one && soe_q && !asleep) |=> asleep);

    assert_nmi_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && active_rank != '0) |-> (take_req && take_vec == VEC_W'(NUM_IRQ)));

endmodule

bind irq_prio_gate irq_prio_gate_chk #(
    .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .take_req(take_req), .take_vec(take_vec),
    .take_ack(take_ack), .exit_ack(exit_ack), .nmi_pend(nmi_pend),
    .gmask_q(gmask_q), .soe_q(soe_q), .active_rank(active_rank),
    .depth_one(depth_one), .wake(wake), .asleep(asleep)
);

// File: tb/irq_prio_gate_bench.sv
module irq_prio_gate_bench;

    localparam int N  = 8;
    localparam int PW = 3;
    localparam int AW = 4;
    localparam int VW = 4;
    localparam int IDLE = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [PW-1:0] cfg_wdata = '0;
    logic [N-1:0]  irq_pend = '0;
    logic          nmi_pend = 1'b0;
    logic          sleep_req = 1'b0;
    logic          sleep_wfe = 1'b0;
    logic          take_ack = 1'b0;
    logic          exit_ack = 1'b0;
    logic          take_req;
    logic [VW-1:0] take_vec;
    logic          wake;
    logic          asleep;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    int prio_s [N];
    int gm_s   = 0;
    int base_s = 0;

    irq_prio_gate u_irq_prio_gate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .irq_pend(irq_pend), .nmi_pend(nmi_pend),
        .sleep_req(sleep_req), .sleep_wfe(sleep_wfe), .take_ack(take_ack),
        .exit_ack(exit_ack), .take_req(take_req), .take_vec(take_vec),
        .wake(wake), .asleep(asleep)
    );

    always #5 clk = ~clk;

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            report();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = PW'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < N) prio_s[addr] = data;
        else if (addr == N) gm_s = data & 1;
        else if (addr == N + 1) base_s = data;
    endtask

    task automatic pulse_take();
        @(negedge clk); take_ack = 1'b1;
        @(negedge clk); take_ack = 1'b0;
    endtask

    task automatic pulse_exit();
        @(negedge clk); exit_ack = 1'b1;
        @(negedge clk); exit_ack = 1'b0;
    endtask

    task automatic pulse_sleep(input bit wfe);
        @(negedge clk); sleep_req = 1'b1; sleep_wfe = wfe;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    // Expected winner from the requirements, given the running rank.
    function automatic void model(input logic [N-1:0] pend, input bit nmi, input int act,
                                  output bit tk, output int vec);
        int best = 99;
        tk = 0; vec = 0;
        if (nmi && act > 0) begin tk = 1; vec = N; return; end
        for (int i = 0; i < N; i++) begin
            if (pend[i] && gm_s == 0 && (base_s == 0 || prio_s[i] < base_s)
                && prio_s[i] + 1 < act && prio_s[i] < best) begin
                best = prio_s[i]; vec = i; tk = 1;
            end
        end
    endfunction

    task automatic check_sel(input string tag, input int act);
        bit tk; int vec;
        model(irq_pend, nmi_pend, act, tk, vec);
        #2;
        chk({tag, " take_req"}, int'(take_req), int'(tk));
        if (tk) chk({tag, " take_vec"}, int'(take_vec), vec);
    endtask

    initial begin
        for (int i = 0; i < N; i++) prio_s[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state, all levels 0 so all-pending picks line 0
        #2;
        chk("R2 asleep after reset", int'(asleep), 0);
        chk("R2 no take when idle", int'(take_req), 0);
        @(negedge clk); irq_pend = '1;
        #2;
        chk("R2 all levels zero take_req", int'(take_req), 1);
        chk("R2 all levels zero vec", int'(take_vec), 0);
        irq_pend = '0;

        // R1 R3 R4 R10: sweep level patterns, thresholds, block bit, pend masks
        for (int k = 0; k < 40; k++) begin
            for (int i = 0; i < N; i++) wr(i, (i * 5 + k * 3 + (k >> 2)) % 8);
            for (int b = 0; b < 8; b++) begin
                wr(N + 1, b);
                for (int g = 0; g < 2; g++) begin
                    wr(N, g);
                    for (int j = 0; j < 5; j++) begin
                        @(negedge clk);
                        irq_pend = (j == 4) ? '1 : N'((k * 37 + j * 91 + 5) & 255);
                        check_sel("R1/R3/R4/R10 sweep", IDLE);
                    end
                end
            end
        end
        @(negedge clk); irq_pend = '0;
        wr(N, 0); wr(N + 1, 0);

        // R5: nesting and restore
        wr(0, 5); wr(1, 2); wr(2, 2); wr(3, 6);
        for (int i = 4; i < N; i++) wr(i, 7);
        @(negedge clk); irq_pend = 8'h01;
        check_sel("R5 idle take line0", IDLE);
        pulse_take();
        irq_pend = 8'h01; check_sel("R5 same level held", 6);
        @(negedge clk); irq_pend = 8'h08; check_sel("R5 less urgent held", 6);
        @(negedge clk); irq_pend = 8'h06; check_sel("R5 preempt lowest index", 6);
        pulse_take();
        irq_pend = 8'h04; check_sel("R5 equal level under nest", 3);
        pulse_exit();
        check_sel("R5 restored level allows line2", 6);
        @(negedge clk); irq_pend = 8'h00;
        pulse_exit();
        irq_pend = 8'h08; check_sel("R5 back to idle", IDLE);
        @(negedge clk); irq_pend = 8'h00;

        // R9: non-maskable line ignores both masks and does not re-enter
        wr(N, 1); wr(N + 1, 1);
        @(negedge clk); nmi_pend = 1'b1; irq_pend = '1;
        check_sel("R9 nmi beats masks", IDLE);
        pulse_take();
        check_sel("R9 nmi not retaken", 0);
        @(negedge clk); nmi_pend = 1'b0; irq_pend = '0;
        pulse_exit();
        wr(N, 0); wr(N + 1, 0);

        // R6: wait-for-interrupt
        wr(N + 1, 3);
        @(negedge clk); irq_pend = 8'h01;  // line0 level 5, blocked by threshold
        pulse_sleep(1'b0);
        #2;
        chk("R6 asleep after entry", int'(asleep), 1);
        chk("R6 threshold-blocked no wake", int'(wake), 0);
        @(negedge clk); @(negedge clk); #2;
        chk("R6 still asleep", int'(asleep), 1);
        wr(N, 1);
        @(negedge clk); irq_pend = 8'h03;
        #2;
        chk("R6 block bit still wakes", int'(wake), 1);
        chk("R6 block bit holds take", int'(take_req), 0);
        @(negedge clk); #2;
        chk("R6 left sleep", int'(asleep), 0);
        wr(N, 0);
        check_sel("R6 take after block cleared", IDLE);
        @(negedge clk); irq_pend = '0;
        wr(N + 1, 0);

        // R7: wait-for-event
        wr(N, 1);
        pulse_sleep(1'b1);
        #2; chk("R7 asleep", int'(asleep), 1);
        @(negedge clk); irq_pend = 8'h01;
        #2;
        chk("R7 masked wakes", int'(wake), 1);
        chk("R7 masked no take", int'(take_req), 0);
        @(negedge clk); #2; chk("R7 resumed", int'(asleep), 0);
        irq_pend = '0;
        wr(N, 0);
        pulse_sleep(1'b1);
        @(negedge clk); irq_pend = 8'h02;
        #2;
        chk("R7 unmasked wakes", int'(wake), 1);
        chk("R7 unmasked takes", int'(take_req), 1);
        chk("R7 unmasked vec", int'(take_vec), 1);
        @(negedge clk); irq_pend = '0;

        // R8: sleep-on-exit
        wr(N + 2, 1);
        @(negedge clk); irq_pend = 8'h02;
        pulse_take();
        irq_pend = '0;
        pulse_exit();
        #2; chk("R8 re-enters sleep", int'(asleep), 1);
        @(negedge clk); irq_pend = 8'h02;
        #2; chk("R8 wakes again", int'(wake), 1);
        @(negedge clk); irq_pend = '0;
        #2; chk("R8 awake", int'(asleep), 0);

        report();
    end

endmodule